// File: doc/BRIEF.md
# Serial EEPROM Target Model

This block is a synthesizable stand-in for a 4-wire serial EEPROM target that holds 256 words of 16 bits. A host drives chip select, serial clock and serial data in. The block answers on a data-out pin that it drives only when its enable output is high. All three inputs are synchronised to the system clock, and the block acts on the rising edges of the serial clock that it detects there.

Each frame begins with a start bit, continues with a 2-bit opcode and then an 8-bit word address. The frame may then carry a 16-bit data word. The block supports word read, word write, word erase, write of one value to every word, erase of every word, and a pair of commands that enable and disable programming. A programming command takes effect when chip select falls after its last bit. A countdown of system clock cycles then stands in for the self-timed programming interval. The host polls the data-out pin to see whether the block is busy or ready.

Top module: `sprom_target`

## Requirements
- R1: While chip select is low, the output enable is low and any partial frame is discarded. The next frame decodes from its own start bit.
- R2: Zeros clocked in before the start bit (a 1) are ignored. The start bit is followed by a 2-bit opcode and an 8-bit address, both MSB first. Opcode codes: 10 read, 01 write, 11 erase. Opcode 00 uses address bits [7:6] to choose: 00 disable writes, 01 write all, 10 erase all, 11 enable writes.
- R3: A read enables the output after the last address bit and drives a 0 first. Each later serial-clock rising edge then presents the next of the 16 data bits, MSB first.
- R4: A write takes 16 data bits MSB first after the address and replaces the word directly, with no erase needed first.
- R5: Erase sets the addressed word to 16'hFFFF. Erase all sets every word to 16'hFFFF.
- R6: Write all sets every word to the 16 data bits of the frame.
- R7: After reset, and after a disable-writes command, programming commands change no word and start no busy interval. An enable-writes command allows them.
- R8: Programming starts on the chip-select fall after the last frame bit. If a serial-clock rising edge arrives first, the command is dropped.
- R9: During the PROG_CYCLES-cycle programming interval, the output is enabled and low whenever chip select is high. Toggling chip select does not disturb the operation.
- R10: Once programming ends, the output is enabled and high whenever chip select is high. This lasts until a start bit is clocked in, which turns the output enable off.
- R11: Frames sent while programming is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_en_o | output | 1 | Drive enable for data out; low means high impedance |

## Verification
The assertions assume the host keeps each serial-clock phase and each data-in setup several system clock cycles long. This ensures every edge is seen after synchronisation and data in is settled when the rising edge is detected. They also assume the host does not raise the serial clock between the last bit of a programming frame and the fall of chip select, unless it means to cancel. The stimulus holds every phase for six system clock cycles and changes data in only while the serial clock is low. It issues random reads, writes, erases and enable or disable commands, and places directed cancels and mid-programming frames at fixed points.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  typedef enum logic [1:0] {
    K_WRITE,
    K_ERASE,
    K_WRALL,
    K_ERALL
  } prog_kind_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_WDIS = 2'b00;
  localparam logic [1:0] SUB_WRAL = 2'b01;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_WEN  = 2'b11;
endpackage

// File: rtl/sprom_sync.sv
module sprom_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic rst_q,
  output logic cs_q,
  output logic di_q,
  output logic sk_rise,
  output logic cs_fall
);
  localparam int NCH = 3;

  logic [STAGES-1:0] rst_ff;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_ff[STAGES-1];

  logic [NCH-1:0] raw, synced;
  assign raw = {cs_i, sk_i, di_i};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) ff <= '0;
      else        ff <= {ff[STAGES-2:0], raw[c]};
    end
    assign synced[c] = ff[STAGES-1];
  end

  logic sk_prev, cs_prev;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sk_prev <= 1'b0;
      cs_prev <= 1'b0;
    end else begin
      sk_prev <= synced[1];
      cs_prev <= synced[2];
    end
  end

  assign cs_q    = synced[2];
  assign di_q    = synced[0];
  assign sk_rise = synced[1] & ~sk_prev;
  assign cs_fall = cs_prev & ~synced[2];
endmodule

// File: rtl/sprom_frame.sv
module sprom_frame
  import sprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_q,
  input  logic              di_q,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output prog_kind_e        prog_kind,
  output logic              prog_req,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              start_seen,
  output logic              rd_active,
  output logic              rd_bit
);
  localparam int HDR_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_ARM, ST_READ, ST_DONE} st_e;

  st_e               st_q, st_d;
  logic [HDR_W-2:0]  hdr_q, hdr_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [DATA_W:0]   rsr_q, rsr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  prog_kind_e        kind_q, kind_d;
  logic [HDR_W-1:0]  full;

  assign full    = {hdr_q, di_q};
  assign rd_addr = full[ADDR_W-1:0];

  always_comb begin
    st_d       = st_q;
    hdr_d      = hdr_q;
    dat_d      = dat_q;
    rsr_d      = rsr_q;
    cnt_d      = cnt_q;
    kind_d     = kind_q;
    wen_set    = 1'b0;
    wen_clr    = 1'b0;
    start_seen = 1'b0;
    if (!cs_q) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (sk_rise) begin
      case (st_q)
        ST_IDLE: begin
          if (di_q && !busy) begin
            start_seen = 1'b1;
            st_d       = ST_HDR;
            cnt_d      = '0;
          end
        end
        ST_HDR: begin
          hdr_d = full[HDR_W-2:0];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            cnt_d = '0;
            case (full[HDR_W-1 -: 2])
              OP_READ: begin
                st_d  = ST_READ;
                rsr_d = {1'b0, rd_data};
              end
              OP_WRITE: begin
                st_d   = ST_DATA;
                kind_d = K_WRITE;
              end
              OP_ERASE: begin
                st_d   = ST_ARM;
                kind_d = K_ERASE;
              end
              default: begin
                case (full[ADDR_W-1 -: 2])
                  SUB_WDIS: begin
                    wen_clr = 1'b1;
                    st_d    = ST_DONE;
                  end
                  SUB_WRAL: begin
                    st_d   = ST_DATA;
                    kind_d = K_WRALL;
                  end
                  SUB_ERAL: begin
                    st_d   = ST_ARM;
                    kind_d = K_ERALL;
                  end
                  default: begin
                    wen_set = 1'b1;
                    st_d    = ST_DONE;
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          dat_d = {dat_q[DATA_W-2:0], di_q};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            cnt_d = '0;
            st_d  = ST_ARM;
          end
        end
        ST_ARM:  st_d  = ST_DONE;
        ST_READ: rsr_d = {rsr_q[DATA_W-1:0], 1'b0};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hdr_q  <= '0;
      dat_q  <= '0;
      rsr_q  <= '0;
      cnt_q  <= '0;
      kind_q <= K_WRITE;
    end else begin
      st_q   <= st_d;
      hdr_q  <= hdr_d;
      dat_q  <= dat_d;
      rsr_q  <= rsr_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  assign prog_req  = (st_q == ST_ARM) && cs_fall;
  assign prog_addr = hdr_q[ADDR_W-1:0];
  assign prog_data = dat_q;
  assign prog_kind = kind_q;
  assign rd_active = (st_q == ST_READ);
  assign rd_bit    = rsr_q[DATA_W];

  // R3: the first bit shown on entering a read is the dummy zero
  p_dummy_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_READ) |-> !rsr_q[DATA_W]);

  // R11: no programming request can be raised while busy
  p_quiet_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_req);

  // R1: chip select low returns the frame logic to idle
  p_idle_after_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> (st_q == ST_IDLE));
endmodule

// File: rtl/sprom_store.sv
module sprom_store
  import sprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  prog_kind_e        prog_kind,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              wen_set,
  input  logic              wen_clr,
  input  logic              start_seen,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              show
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int PC_W  = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [PC_W-1:0]   cnt_q, cnt_d;
  logic              wen_q, wen_d, show_q, show_d;
  logic              go, wide;
  logic [DATA_W-1:0] wval;

  assign busy = (cnt_q != '0);
  assign go   = prog_req && wen_q && !busy;
  assign wide = (prog_kind == K_WRALL) || (prog_kind == K_ERALL);
  assign wval = ((prog_kind == K_ERASE) || (prog_kind == K_ERALL)) ? '1 : prog_data;

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (go && (wide || (prog_addr == ADDR_W'(i)))) mem_q[i] <= wval;
    end
  end

  assign rd_data = mem_q[rd_addr];

  always_comb begin
    cnt_d  = cnt_q;
    wen_d  = wen_q;
    show_d = show_q;
    if (go)        cnt_d = PC_W'(PROG_CYCLES);
    else if (busy) cnt_d = cnt_q - 1'b1;
    if (wen_set)      wen_d = 1'b1;
    else if (wen_clr) wen_d = 1'b0;
    if (go)              show_d = 1'b1;
    else if (start_seen) show_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wen_q  <= 1'b0;
      show_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wen_q  <= wen_d;
      show_q <= show_d;
    end
  end

  assign show = show_q;

  // R7: a busy interval only begins while writes are enabled
  p_start_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));

  // R9: the interval ends only after its countdown reaches its last count
  p_interval_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt_q) == PC_W'(1)));

  // R9: an interval begins with the status shown
  p_status_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> show_q);
endmodule

// File: rtl/sprom_target.sv
module sprom_target
  import sprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_en_o
);
  logic              rst_q, cs_q, di_q, sk_rise, cs_fall;
  logic [ADDR_W-1:0] rd_addr, prog_addr;
  logic [DATA_W-1:0] rd_data, prog_data;
  prog_kind_e        prog_kind;
  logic              prog_req, wen_set, wen_clr, start_seen;
  logic              rd_active, rd_bit, busy, show;

  sprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
    .rst_q(rst_q), .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  sprom_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_q), .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise),
    .cs_fall(cs_fall), .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_kind(prog_kind),
    .prog_req(prog_req), .wen_set(wen_set), .wen_clr(wen_clr),
    .start_seen(start_seen), .rd_active(rd_active), .rd_bit(rd_bit)
  );

  sprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_q), .prog_req(prog_req), .prog_kind(prog_kind),
    .prog_addr(prog_addr), .prog_data(prog_data), .wen_set(wen_set),
    .wen_clr(wen_clr), .start_seen(start_seen), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .show(show)
  );

  assign do_en_o = cs_q && (rd_active || show);
  assign do_o    = rd_active ? rd_bit : !busy;

  // R1: output released in the cycle chip select is seen falling
  p_release_on_deselect_r1: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(cs_q) |-> !do_en_o);

  // R10: ready keeps being shown while selected until a start bit arrives
  p_ready_held_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (do_en_o && do_o && !rd_active && cs_q && !start_seen) |=> (!cs_q || do_en_o));
endmodule

// File: tb/tb_sprom_target.sv
module tb_sprom_target;
  localparam int H    = 6;
  localparam int PROG = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_en;

  always #5 clk = ~clk;

  sprom_target #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_o), .do_en_o(do_en)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [256];
  bit wen_m = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input bit b);
    di = b;
    tick(H);
    sk = 1'b1;
    tick(H);
    sk = 1'b0;
  endtask

  task automatic sel;
    cs = 1'b1;
    tick(H);
  endtask

  task automatic desel;
    cs = 1'b0;
    di = 1'b0;
    tick(2 * H);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [7:0] a);
    sbit(1'b1);
    for (int i = 1; i >= 0; i--) sbit(op[i]);
    for (int i = 7; i >= 0; i--) sbit(a[i]);
  endtask

  // model update: what a programming command does to the words
  function automatic void apply(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    if (!wen_m) return;
    if (op == 2'b01) model[a] = d;
    else if (op == 2'b11) model[a] = 16'hFFFF;
    else if (a[7:6] == 2'b01) for (int i = 0; i < 256; i++) model[i] = d;
    else if (a[7:6] == 2'b10) for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
  endfunction

  task automatic rd_check(input string req, input logic [7:0] a, input int zeros);
    logic [15:0] d;
    logic dummy;
    logic en_all;
    sel;
    for (int i = 0; i < zeros; i++) sbit(1'b0);
    hdr(2'b10, a);
    di = 1'b0;
    en_all = 1'b1;
    dummy = 1'b1;
    d = '0;
    for (int k = 0; k < 17; k++) begin
      tick(H);
      en_all = en_all & do_en;
      if (k == 0) dummy = do_o;
      else d = {d[14:0], do_o};
      sk = 1'b1;
      tick(H);
      sk = 1'b0;
    end
    desel;
    check({req, " R3 enable"}, 32'(en_all), 32'd1);
    check({req, " R3 dummy"}, 32'(dummy), 32'd0);
    check({req, " data"}, 32'(d), 32'(model[a]));
  endtask

  task automatic prog(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                      input bit has_d, input bit cancel);
    sel;
    hdr(op, a);
    if (has_d) for (int i = 15; i >= 0; i--) sbit(d[i]);
    if (cancel) sbit(1'b0);
    desel;
  endtask

  task automatic expect_busy(input string req);
    sel;
    check({req, " busy en"}, 32'(do_en), 32'd1);
    check({req, " busy low"}, 32'(do_o), 32'd0);
  endtask

  task automatic wait_ready(input string req);
    int n;
    n = 0;
    while (!(do_en && do_o) && n < PROG + 100) begin
      tick(1);
      n++;
    end
    check({req, " R10 ready"}, 32'({do_en, do_o}), 32'b11);
  endtask

  task automatic clear_status;
    sbit(1'b1);
    check("R10 cleared by start bit", 32'(do_en), 32'd0);
    desel;
  endtask

  task automatic expect_nothing(input string req);
    sel;
    check({req, " no status"}, 32'(do_en), 32'd0);
    desel;
  endtask

  task automatic full_prog(input string req, input logic [1:0] op, input logic [7:0] a,
                           input logic [15:0] d, input bit has_d);
    prog(op, a, d, has_d, 1'b0);
    if (wen_m) begin
      apply(op, a, d);
      expect_busy({req, " R9"});
      wait_ready(req);
      clear_status;
    end else begin
      expect_nothing({req, " R7"});
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    tick(10);
    check("R1 reset output", 32'(do_en), 32'd0);
    rst_n = 1'b1;
    tick(10);

    // enable, then erase all
    prog(2'b00, 8'hC0, 16'h0, 1'b0, 1'b0);
    wen_m = 1'b1;
    full_prog("R5 erase all", 2'b00, 8'h80, 16'h0, 1'b0);
    rd_check("R5 erase all lo", 8'h00, 0);
    rd_check("R5 erase all hi", 8'hFF, 0);

    full_prog("R6 write all", 2'b00, 8'h40, 16'hA5C3, 1'b1);
    rd_check("R6 word 00", 8'h00, 0);
    rd_check("R6 word 7F", 8'h7F, 0);

    full_prog("R5 erase", 2'b11, 8'h7F, 16'h0, 1'b0);
    rd_check("R5 erased word", 8'h7F, 0);
    rd_check("R5 neighbour", 8'h7E, 0);

    full_prog("R4 write", 2'b01, 8'h7E, 16'h1234, 1'b1);
    rd_check("R4 overwrite", 8'h7E, 0);

    // R8: an extra clock before deselect drops the command
    prog(2'b01, 8'h20, 16'hBEEF, 1'b1, 1'b1);
    expect_nothing("R8 cancel");
    rd_check("R8 cancel word", 8'h20, 0);

    // R9 toggling and R11 frames during busy
    prog(2'b01, 8'h30, 16'h0F0F, 1'b1, 1'b0);
    apply(2'b01, 8'h30, 16'h0F0F);
    for (int t = 0; t < 3; t++) begin
      expect_busy("R9 toggle");
      desel;
    end
    prog(2'b01, 8'h31, 16'h5555, 1'b1, 1'b0);
    sel;
    wait_ready("R9 after toggle");
    desel;
    sel;
    check("R10 ready held across deselect", 32'({do_en, do_o}), 32'b11);
    clear_status;
    rd_check("R9 programmed word", 8'h30, 0);
    rd_check("R11 ignored frame", 8'h31, 0);

    rd_check("R2 leading zeros", 8'h30, 3);

    // R1: partial frame then deselect
    sel;
    sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1); sbit(1'b0);
    desel;
    rd_check("R1 after partial frame", 8'h7E, 0);

    // R7: disable blocks writes and erases
    prog(2'b00, 8'h00, 16'h0, 1'b0, 1'b0);
    wen_m = 1'b0;
    full_prog("R7 blocked write", 2'b01, 8'h40, 16'hDEAD, 1'b1);
    full_prog("R7 blocked erase", 2'b11, 8'h30, 16'h0, 1'b0);
    rd_check("R7 word kept", 8'h40, 0);
    rd_check("R7 erase kept", 8'h30, 0);

    // random mix
    for (int r = 0; r < 36; r++) begin
      int sel_op;
      logic [7:0] a;
      logic [15:0] d;
      sel_op = int'($urandom_range(0, 9));
      a = 8'($urandom);
      d = 16'($urandom);
      if (sel_op == 0) begin
        prog(2'b00, {2'b11, a[5:0]}, 16'h0, 1'b0, 1'b0);
        wen_m = 1'b1;
      end else if (sel_op == 1) begin
        prog(2'b00, {2'b00, a[5:0]}, 16'h0, 1'b0, 1'b0);
        wen_m = 1'b0;
      end else if (sel_op <= 4) begin
        full_prog("R4 random write", 2'b01, a, d, 1'b1);
      end else if (sel_op == 5) begin
        full_prog("R5 random erase", 2'b11, a, 16'h0, 1'b0);
      end else begin
        rd_check("R3 random read", a, int'($urandom_range(0, 2)));
      end
    end
    rd_check("R4 final", 8'h7E, 0);
    finish_up();
  end
endmodule